// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Monitor

This block sits beside an SDRAM controller and watches the command pins it drives: clock enable, chip select, and the row strobe, column strobe and write enable. It also takes one idle bit for each bank. From these inputs it follows the device through its low-power states. It reports which state the device is in and raises a one-cycle flag when the controller breaks a clock-enable rule. A ready output tells the controller when ordinary commands may be issued again.

The monitor keeps its own copy of clock enable from the previous edge. It classifies every edge by that earlier sample together with the present one. Four states are tracked. ACTIVE covers normal operation. PDOWN is power-down. SREF is self-refresh. RECOVER is the wait after self-refresh that lasts `TRC_CYCLES` clocks.

The named transitions are:
- ENTER_PD: ACTIVE to PDOWN.
- ENTER_SR: ACTIVE to SREF.
- EXIT_PD: PDOWN to ACTIVE.
- EXIT_SR: SREF to RECOVER.
- RECOVER_DONE: RECOVER to ACTIVE.
- HOLD: a low-power state stays where it is.
- REJECT: an entry attempt fails and the state stays ACTIVE.

Top module: `cke_pwr_monitor`

## Requirements
- R1: Reset is asynchronous and active low. During and after reset, `pwr_state` is ACTIVE (2'b00), `ready` is 1 and `illegal` is 0. The internal previous clock-enable sample resets high, so clock enable low on the first edge is treated as a high-to-low transition.
- R2: ENTER_PD happens on an edge where clock enable was high before and is low now, every bank is idle, and the bus carries NOP or deselect. On that edge the state moves to PDOWN (2'b01) and `ready` goes low. Deselect is cs_n=1. NOP is cs_n=0 with ras_n=cas_n=we_n=1.
- R3: ENTER_SR happens on the same high-to-low edge with every bank idle and the self-refresh command on the bus. The self-refresh command is cs_n=0, ras_n=0, cas_n=0, we_n=1. The state moves to SREF (2'b10).
- R4: A high-to-low attempt with NOP, deselect or self-refresh while any bank is busy follows REJECT. The state stays ACTIVE and `illegal` pulses.
- R5: A high-to-low edge in ACTIVE that carries any other command also follows REJECT and pulses `illegal`.
- R6: While clock enable stays low in PDOWN or SREF, the state holds and every command is ignored: no `illegal` pulse and no change of state.
- R7: In PDOWN, clock enable low-to-high takes EXIT_PD. The state is ACTIVE and `ready` is 1 from the next cycle.
- R8: In SREF, clock enable low-to-high takes EXIT_SR to RECOVER (2'b11). `ready` stays low for exactly `TRC_CYCLES` cycles, then RECOVER_DONE returns the state to ACTIVE.
- R9: Any exit edge that carries a command other than NOP or deselect pulses `illegal`. The exit still takes place.
- R10: In RECOVER, every edge that carries a command other than NOP or deselect pulses `illegal`.
- R11: In ACTIVE, an edge with clock enable high both before and now never pulses `illegal`, whatever the command.
- R12: `illegal` is registered. It is high in exactly the one cycle after each offending edge, and low in the cycle after any edge that does not offend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable as driven to the device |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_idle | input | NUM_BANKS | One bit per bank, 1 = bank idle |
| pwr_state | output | 2 | 00 ACTIVE, 01 PDOWN, 10 SREF, 11 RECOVER |
| illegal | output | 1 | One-cycle violation pulse |
| ready | output | 1 | Device accepts normal commands |

## Verification
The hardest case to reach from the ports is a late command inside the recovery window. It takes a full self-refresh entry with every bank idle, a held low period, and a clean exit. Only then does the bench count recovery clocks and place an activate command a few edges before RECOVER_DONE. The bench drives that sequence with several exit commands and checks every cycle against a behavioural model. That model counts the remaining recovery cycles on its own.

// File: rtl/cke_pwr_pkg.sv
package cke_pwr_pkg;

    typedef enum logic [1:0] {
        PS_ACTIVE  = 2'b00,
        PS_PDOWN   = 2'b01,
        PS_SREF    = 2'b10,
        PS_RECOVER = 2'b11
    } pwr_state_t;

    typedef enum logic [1:0] {
        CC_DESEL = 2'b00,
        CC_NOP   = 2'b01,
        CC_SREF  = 2'b10,
        CC_OTHER = 2'b11
    } cmd_class_t;

    function automatic logic is_quiet(input cmd_class_t c);
        return (c == CC_DESEL) || (c == CC_NOP);
    endfunction

endpackage

// File: rtl/cke_cmd_class.sv
module cke_cmd_class
    import cke_pwr_pkg::*;
(
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    output cmd_class_t cls
);

    always_comb begin
        if (cs_n) begin
            cls = CC_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cls = CC_NOP;
                3'b001:  cls = CC_SREF;
                default: cls = CC_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/cke_rec_timer.sv
module cke_rec_timer #(
    parameter int TRC_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);

    localparam int CW = (TRC_CYCLES < 2) ? 1 : $clog2(TRC_CYCLES);
    localparam logic [CW-1:0] START = CW'(TRC_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= START;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/cke_pwr_fsm.sv
module cke_pwr_fsm
    import cke_pwr_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke,
    input  logic                 cke_prev,
    input  cmd_class_t           cls,
    input  logic [NUM_BANKS-1:0] bank_idle,
    input  logic                 timer_done,
    output pwr_state_t           state,
    output logic                 timer_load,
    output logic                 illegal
);

    pwr_state_t state_q, state_d;
    logic       ill_d, ill_q;
    logic       all_idle, quiet, fall, rise;

    assign all_idle = &bank_idle;
    assign quiet    = is_quiet(cls);
    assign fall     = cke_prev && !cke;
    assign rise     = !cke_prev && cke;

    always_comb begin
        state_d    = state_q;
        ill_d      = 1'b0;
        timer_load = 1'b0;
        unique case (state_q)
            PS_ACTIVE: begin
                if (fall) begin
                    if (quiet && all_idle) begin
                        state_d = PS_PDOWN;
                    end else if ((cls == CC_SREF) && all_idle) begin
                        state_d = PS_SREF;
                    end else begin
                        ill_d = 1'b1;
                    end
                end
            end
            PS_PDOWN: begin
                if (cke_prev) begin
                    ill_d = 1'b1;
                end else if (rise) begin
                    state_d = PS_ACTIVE;
                    ill_d   = !quiet;
                end
            end
            PS_SREF: begin
                if (cke_prev) begin
                    ill_d = 1'b1;
                end else if (rise) begin
                    state_d    = PS_RECOVER;
                    timer_load = 1'b1;
                    ill_d      = !quiet;
                end
            end
            PS_RECOVER: begin
                ill_d = !quiet;
                if (timer_done) begin
                    state_d = PS_ACTIVE;
                end
            end
            default: state_d = PS_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ill_q <= 1'b0;
        end else begin
            ill_q <= ill_d;
        end
    end

    assign state   = state_q;
    assign illegal = ill_q;

endmodule

// File: rtl/cke_pwr_monitor.sv
module cke_pwr_monitor
    import cke_pwr_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int TRC_CYCLES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [NUM_BANKS-1:0] bank_idle,
    output logic [1:0]           pwr_state,
    output logic                 illegal,
    output logic                 ready
);

    cmd_class_t cls;
    pwr_state_t state;
    logic       cke_prev;
    logic       timer_load, timer_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cke_prev <= 1'b1;
        end else begin
            cke_prev <= cke;
        end
    end

    cke_cmd_class u_class (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cls   (cls)
    );

    cke_rec_timer #(.TRC_CYCLES(TRC_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (timer_load),
        .run   (state == PS_RECOVER),
        .done  (timer_done)
    );

    cke_pwr_fsm #(.NUM_BANKS(NUM_BANKS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke        (cke),
        .cke_prev   (cke_prev),
        .cls        (cls),
        .bank_idle  (bank_idle),
        .timer_done (timer_done),
        .state      (state),
        .timer_load (timer_load),
        .illegal    (illegal)
    );

    assign pwr_state = state;
    assign ready     = (state == PS_ACTIVE);

endmodule

// File: rtl/cke_pwr_checker.sv
module cke_pwr_checker
    import cke_pwr_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int TRC_CYCLES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cke,
    input logic                 cke_prev,
    input logic                 cs_n,
    input logic                 ras_n,
    input logic                 cas_n,
    input logic                 we_n,
    input logic [NUM_BANKS-1:0] bank_idle,
    input logic [1:0]           pwr_state,
    input logic                 illegal,
    input logic                 ready
);

    logic quiet_cmd;
    assign quiet_cmd = cs_n || (ras_n && cas_n && we_n);

    int unsigned rec_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_len <= 0;
        end else if (pwr_state == PS_RECOVER) begin
            rec_len <= rec_len + 1;
        end else begin
            rec_len <= 0;
        end
    end

    a_r2_pd_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PS_ACTIVE && cke_prev && !cke && (&bank_idle) && quiet_cmd)
        |=> (pwr_state == PS_PDOWN && !ready));

    a_r4_busy_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PS_ACTIVE && cke_prev && !cke && !(&bank_idle))
        |=> (pwr_state == PS_ACTIVE && illegal));

    a_r6_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwr_state == PS_PDOWN || pwr_state == PS_SREF) && !cke)
        |=> ($stable(pwr_state) && !illegal));

    a_r7_pd_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PS_PDOWN && cke)
        |=> (pwr_state == PS_ACTIVE && ready));

    a_r8_sr_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PS_SREF && cke)
        |=> (pwr_state == PS_RECOVER && !ready));

    a_r8_recover_len: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != PS_RECOVER && rec_len != 0) |-> (rec_len == TRC_CYCLES));

    a_r10_recover_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PS_RECOVER && !quiet_cmd) |=> illegal);

    a_r11_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PS_ACTIVE && cke_prev && cke) |=> !illegal);

endmodule

bind cke_pwr_monitor cke_pwr_checker #(
    .NUM_BANKS  (NUM_BANKS),
    .TRC_CYCLES (TRC_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .cke_prev  (cke_prev),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .bank_idle (bank_idle),
    .pwr_state (pwr_state),
    .illegal   (illegal),
    .ready     (ready)
);

// File: tb/cke_pwr_monitor_tb_top.sv
module cke_pwr_monitor_tb_top;

    localparam int NB  = 4;
    localparam int TRC = 5;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_DES = 4'b1111;
    localparam logic [3:0] C_SRF = 4'b0001;
    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke = 1'b1;
    logic [3:0]    cmd = C_NOP;
    logic [NB-1:0] bank_idle = '1;
    logic [1:0]    pwr_state;
    logic          illegal;
    logic          ready;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    finished = 0;

    always #2 clk = ~clk;

    cke_pwr_monitor #(.NUM_BANKS(NB), .TRC_CYCLES(TRC)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke       (cke),
        .cs_n      (cmd[3]),
        .ras_n     (cmd[2]),
        .cas_n     (cmd[1]),
        .we_n      (cmd[0]),
        .bank_idle (bank_idle),
        .pwr_state (pwr_state),
        .illegal   (illegal),
        .ready     (ready)
    );

    // Behavioural reference: 0 active, 1 power-down, 2 self-refresh, 3 recovering
    int m_state, m_remain, m_ill, m_prev;
    int n_state, n_ill;
    bit b_quiet, b_srf, b_idle;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_remain = 0; m_ill = 0; m_prev = 1;
        end else begin
            b_quiet = cmd[3] || (cmd[2:0] == 3'b111);
            b_srf   = (cmd == C_SRF);
            b_idle  = (bank_idle == {NB{1'b1}});
            n_state = m_state;
            n_ill   = 0;
            if (m_state == 0) begin
                if (m_prev == 1 && !cke) begin
                    if (b_idle && b_quiet)    n_state = 1;
                    else if (b_idle && b_srf) n_state = 2;
                    else                      n_ill = 1;
                end
            end else if (m_state == 1 || m_state == 2) begin
                if (m_prev == 1) n_ill = 1;
                else if (cke) begin
                    n_ill = b_quiet ? 0 : 1;
                    if (m_state == 1) n_state = 0;
                    else begin n_state = 3; m_remain = TRC; end
                end
            end else begin
                n_ill = b_quiet ? 0 : 1;
                m_remain = m_remain - 1;
                if (m_remain == 0) n_state = 0;
            end
            m_state = n_state;
            m_ill   = n_ill;
            m_prev  = cke ? 1 : 0;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string req);
        check(req, "pwr_state", int'(pwr_state), m_state);
        check(req, "ready", int'(ready), (m_state == 0) ? 1 : 0);
        check(req, "illegal", int'(illegal), m_ill);
    endtask

    // one clock: compare outputs of the previous edge, then drive new inputs
    task automatic cyc(input string req, input logic k, input logic [3:0] c, input logic [NB-1:0] idl);
        @(negedge clk);
        compare_all(cur_req);
        cur_req   = req;
        cke       = k;
        cmd       = c;
        bank_idle = idl;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "pwr_state in reset", int'(pwr_state), 0);
        check("R1", "ready in reset", int'(ready), 1);
        check("R1", "illegal in reset", int'(illegal), 0);
        rst_n = 1'b1;

        // R1: first edge after reset with cke low counts as high-to-low
        cyc("R1", 1'b0, C_NOP, 4'hF);
        cyc("R7", 1'b1, C_NOP, 4'hF);
        cyc("R7", 1'b1, C_NOP, 4'hF);

        // R11: any command with cke steady high
        cyc("R11", 1'b1, C_ACT, 4'h3);
        cyc("R11", 1'b1, C_RD, 4'h0);
        cyc("R11", 1'b1, C_SRF, 4'h0);
        cyc("R11", 1'b1, C_NOP, 4'hF);

        // R2 + R6 + R7: power-down via NOP, hold with noise, clean exit
        cyc("R2", 1'b0, C_NOP, 4'hF);
        cyc("R6", 1'b0, C_RD, 4'h0);
        cyc("R6", 1'b0, C_ACT, 4'hF);
        cyc("R6", 1'b0, C_SRF, 4'hF);
        cyc("R7", 1'b1, C_DES, 4'hF);
        cyc("R7", 1'b1, C_NOP, 4'hF);

        // R2 via deselect, R9 exit with a real command
        cyc("R2", 1'b0, C_DES, 4'hF);
        cyc("R6", 1'b0, C_DES, 4'hF);
        cyc("R9", 1'b1, C_ACT, 4'hF);
        cyc("R12", 1'b1, C_NOP, 4'hF);
        cyc("R12", 1'b1, C_NOP, 4'hF);

        // R4: entry with a busy bank, NOP then self-refresh
        cyc("R4", 1'b0, C_NOP, 4'b1011);
        cyc("R12", 1'b0, C_NOP, 4'hF);
        cyc("R12", 1'b1, C_NOP, 4'hF);
        cyc("R4", 1'b0, C_SRF, 4'b0111);
        cyc("R12", 1'b1, C_NOP, 4'hF);

        // R5: high-to-low with a read, all idle
        cyc("R5", 1'b0, C_RD, 4'hF);
        cyc("R12", 1'b1, C_NOP, 4'hF);
        cyc("R12", 1'b1, C_NOP, 4'hF);

        // R3 + R6 + R8: self-refresh, hold, clean exit, full recovery
        cyc("R3", 1'b0, C_SRF, 4'hF);
        cyc("R6", 1'b0, C_RD, 4'h0);
        cyc("R6", 1'b0, C_NOP, 4'hF);
        cyc("R6", 1'b0, C_ACT, 4'hF);
        cyc("R8", 1'b1, C_NOP, 4'hF);
        for (int i = 0; i < TRC + 2; i++) cyc("R8", 1'b1, (i % 2 == 0) ? C_NOP : C_DES, 4'hF);

        // R10: command late in recovery, back-to-back offences
        cyc("R3", 1'b0, C_SRF, 4'hF);
        cyc("R6", 1'b0, C_NOP, 4'hF);
        cyc("R8", 1'b1, C_DES, 4'hF);
        cyc("R8", 1'b1, C_NOP, 4'hF);
        cyc("R10", 1'b1, C_NOP, 4'hF);
        cyc("R10", 1'b1, C_ACT, 4'hF);
        cyc("R10", 1'b1, C_RD, 4'hF);
        cyc("R10", 1'b1, C_ACT, 4'hF);
        cyc("R12", 1'b1, C_NOP, 4'hF);
        cyc("R12", 1'b1, C_NOP, 4'hF);

        // R9: self-refresh exit carrying a read, recovery still runs
        cyc("R3", 1'b0, C_SRF, 4'hF);
        cyc("R9", 1'b1, C_RD, 4'hF);
        for (int i = 0; i < TRC + 1; i++) cyc("R8", 1'b1, C_NOP, 4'hF);

        // R1: reset in the middle of power-down returns to active
        cyc("R2", 1'b0, C_NOP, 4'hF);
        cyc("R6", 1'b0, C_NOP, 4'hF);
        @(negedge clk);
        compare_all(cur_req);
        rst_n = 1'b0;
        #1;
        check("R1", "pwr_state after reset", int'(pwr_state), 0);
        check("R1", "ready after reset", int'(ready), 1);
        check("R1", "illegal after reset", int'(illegal), 0);
        cke = 1'b1;
        cur_req = "R1";
        @(negedge clk);
        rst_n = 1'b1;
        cyc("R11", 1'b1, C_NOP, 4'hF);
        cyc("R11", 1'b1, C_NOP, 4'hF);
        @(negedge clk);
        compare_all(cur_req);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule